// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block schedules the background memory reads of a tile-based raster renderer. A free-running horizontal dot count comes in from the line timing logic. Inside each tile period of eight dots, the block issues four reads on an external video memory port, always in the same order: the name byte first, then the attribute byte, then the low pattern plane, then the high pattern plane. Each read takes two clocks. The address and the read strobe appear in the first clock, and the returned byte is captured at the end of the second clock.

Once the high plane byte is captured, the block raises a one-clock load pulse. With that pulse it presents the two pattern bytes and a 2-bit palette select to the downstream pixel shifter. The palette select is never read over the memory port. It is cut out of the attribute byte inside the block.

Fetches run two tiles ahead of display. At the end of each line the block reloads its coarse column counter from the scroll input and prefetches two tiles. The first tile fetched in the next line's visible window is therefore the third tile on screen. Fetch timing depends only on the dot count, never on fine scroll.

Top module: `tile_fetch_seq`

## Requirements
- R1: While `rst` is high and in the first clock after it, `vram_rd` and `tile_load` are 0 and `tile_lo`, `tile_hi`, `tile_pal` are all 0. The coarse column counter resets to 0.
- R2: `vram_rd` is 1 only when `render_en` is 1, the dot lies in 1..256 or 321..336, and the slot number `(dot-1) mod 8` is even. It is 0 on every other dot, so two strobes are never adjacent.
- R3: Slot 0 addresses the name byte at `{2'b10, name_sel, coarse_y, cx}`. Slot 2 addresses the attribute byte at `{2'b10, name_sel, 4'b1111, coarse_y[4:2], cx[4:2]}`. Slot 4 and slot 6 address the pattern planes at `{1'b0, pat_sel, name_byte, plane, fine_y}`, with plane 0 in slot 4 and plane 1 in slot 6. Here `cx` is the internal coarse column.
- R4: The byte on `vram_rdata` during the clock after each strobe is the byte captured for that read. The pattern addresses use the name byte captured earlier in the same period.
- R5: The palette select equals attribute bits `[2k+1:2k]`, where `k = {coarse_y[1], cx[1]}`.
- R6: `tile_load` is high for exactly one clock: the clock after the slot-7 clock of each active period. In that clock `tile_lo`, `tile_hi` and `tile_pal` carry that period's tile. Between pulses these outputs hold their values.
- R7: The coarse column advances by one after each slot-7 clock and wraps from 31 to 0.
- R8: At dot 257 with `render_en` high, the coarse column reloads from `scroll_cx`. The prefetch tiles at dots 321 and 329 use `scroll_cx` and `scroll_cx+1`, and the first visible tile of the next line uses `scroll_cx+2`.
- R9: While `render_en` is 0 there are no strobes and no load pulses, and the coarse column neither advances nor reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | Background fetching enable |
| dot | input | 9 | Horizontal dot count, 0..340 |
| scroll_cx | input | 5 | Coarse horizontal scroll, loaded at dot 257 |
| coarse_y | input | 5 | Coarse tile row |
| fine_y | input | 3 | Pixel row within the tile |
| name_sel | input | 2 | Name table select |
| pat_sel | input | 1 | Pattern table half select |
| vram_rdata | input | 8 | Read data, valid in the clock after a strobe |
| vram_addr | output | 14 | Fetch address, valid while `vram_rd` is high |
| vram_rd | output | 1 | Read strobe |
| tile_load | output | 1 | One-clock hand-off pulse to the shifter |
| tile_lo | output | 8 | Low pattern plane of the handed-off tile |
| tile_hi | output | 8 | High pattern plane of the handed-off tile |
| tile_pal | output | 2 | Palette select of the handed-off tile |

## Verification
The embedded properties guard the behaviours that hold on every clock. Strobes are never adjacent. The load pulse lasts one clock, and the tile outputs stay still between pulses. Each load coincides with a single step of the coarse column. A disabled clock is never followed by a load.

The bench scenarios are needed for everything that depends on data and scroll history. That covers the address encodings and their slot order, the quadrant chosen for the palette select, and the wrap of the column counter. It also covers the two-tile prefetch that makes the first visible fetch land on `scroll+2`. Finally, a disabled line must leave the column untouched until the next reload.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int CX_W   = 5;
    localparam int CY_W   = 5;
    localparam int FY_W   = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 14;
    localparam int PAL_W  = 2;

    // Slot within an 8-clock tile period; the order is behaviour.
    typedef enum logic [2:0] {
        SL_NAME_A = 3'd0,
        SL_NAME_D = 3'd1,
        SL_ATTR_A = 3'd2,
        SL_ATTR_D = 3'd3,
        SL_LO_A   = 3'd4,
        SL_LO_D   = 3'd5,
        SL_HI_A   = 3'd6,
        SL_HI_D   = 3'd7
    } slot_e;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic [PAL_W-1:0]  pal;
    } tile_t;

    function automatic logic [ADDR_W-1:0] name_addr(
        input logic [1:0]      nsel,
        input logic [CY_W-1:0] cy,
        input logic [CX_W-1:0] cx
    );
        return {2'b10, nsel, cy, cx};
    endfunction

    function automatic logic [ADDR_W-1:0] attr_addr(
        input logic [1:0]      nsel,
        input logic [CY_W-1:0] cy,
        input logic [CX_W-1:0] cx
    );
        return {2'b10, nsel, 4'b1111, cy[4:2], cx[4:2]};
    endfunction

    function automatic logic [ADDR_W-1:0] pat_addr(
        input logic              psel,
        input logic [DATA_W-1:0] tile,
        input logic              plane,
        input logic [FY_W-1:0]   fy
    );
        return {1'b0, psel, tile, plane, fy};
    endfunction

    function automatic logic [PAL_W-1:0] pal_pick(
        input logic [DATA_W-1:0] attr,
        input logic              cx1,
        input logic              cy1
    );
        logic [PAL_W-1:0] r;
        case ({cy1, cx1})
            2'b00:   r = attr[1:0];
            2'b01:   r = attr[3:2];
            2'b10:   r = attr[5:4];
            default: r = attr[7:6];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tfs_window.sv
module tfs_window
    import tfs_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int VIS_FIRST = 1,
    parameter int VIS_LAST  = 256,
    parameter int PRE_FIRST = 321,
    parameter int PRE_LAST  = 336
) (
    input  logic             en,
    input  logic [DOT_W-1:0] dot,
    output logic             active,
    output slot_e            slot
);
    logic in_vis;
    logic in_pre;
    logic [DOT_W-1:0] rel;

    always_comb begin
        in_vis = (int'(dot) >= VIS_FIRST) && (int'(dot) <= VIS_LAST);
        in_pre = (int'(dot) >= PRE_FIRST) && (int'(dot) <= PRE_LAST);
        active = en && (in_vis || in_pre);
        rel    = dot - DOT_W'(VIS_FIRST);
        slot   = slot_e'(rel[2:0]);
    end
endmodule

// File: rtl/tfs_coarse.sv
module tfs_coarse
    import tfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic            reload,
    input  logic [CX_W-1:0] scroll,
    output logic [CX_W-1:0] cx
);
    always_ff @(posedge clk) begin
        if (rst)
            cx <= '0;
        else if (reload)
            cx <= scroll;
        else if (step)
            cx <= cx + 1'b1;
    end

    AST_NO_STEP_AND_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !(step && reload)); // R8
endmodule

// File: rtl/tfs_latch.sv
module tfs_latch
    import tfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  slot_e             slot,
    input  logic [DATA_W-1:0] rdata,
    input  logic              cx1,
    input  logic              cy1,
    output logic [DATA_W-1:0] name_byte,
    output tile_t             tile,
    output logic              load
);
    logic [PAL_W-1:0]  pal_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            name_byte <= '0;
            pal_q     <= '0;
            lo_q      <= '0;
            tile      <= '0;
            load      <= 1'b0;
        end else begin
            load <= 1'b0;
            if (active) begin
                case (slot)
                    SL_NAME_D: name_byte <= rdata;
                    SL_ATTR_D: pal_q     <= pal_pick(rdata, cx1, cy1);
                    SL_LO_D:   lo_q      <= rdata;
                    SL_HI_D: begin
                        tile <= '{lo: lo_q, hi: rdata, pal: pal_q};
                        load <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        load |=> !load); // R6
    AST_TILE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |-> $stable(tile)); // R6
endmodule

// File: rtl/tile_fetch_seq.sv
module tile_fetch_seq
    import tfs_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int VIS_FIRST  = 1,
    parameter int VIS_LAST   = 256,
    parameter int PRE_FIRST  = 321,
    parameter int PRE_LAST   = 336,
    parameter int RELOAD_DOT = 257
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              render_en,
    input  logic [DOT_W-1:0]  dot,
    input  logic [4:0]        scroll_cx,
    input  logic [4:0]        coarse_y,
    input  logic [2:0]        fine_y,
    input  logic [1:0]        name_sel,
    input  logic              pat_sel,
    input  logic [7:0]        vram_rdata,
    output logic [13:0]       vram_addr,
    output logic              vram_rd,
    output logic              tile_load,
    output logic [7:0]        tile_lo,
    output logic [7:0]        tile_hi,
    output logic [1:0]        tile_pal
);
    logic              active;
    slot_e             slot;
    logic [CX_W-1:0]   cx;
    logic [DATA_W-1:0] name_byte;
    tile_t             tile;
    logic              step;
    logic              reload;

    tfs_window #(
        .DOT_W(DOT_W), .VIS_FIRST(VIS_FIRST), .VIS_LAST(VIS_LAST),
        .PRE_FIRST(PRE_FIRST), .PRE_LAST(PRE_LAST)
    ) u_window (
        .en(render_en), .dot(dot), .active(active), .slot(slot)
    );

    assign step   = active && (slot == SL_HI_D);
    assign reload = render_en && (int'(dot) == RELOAD_DOT);

    tfs_coarse u_coarse (
        .clk(clk), .rst(rst), .step(step), .reload(reload),
        .scroll(scroll_cx), .cx(cx)
    );

    tfs_latch u_latch (
        .clk(clk), .rst(rst), .active(active), .slot(slot),
        .rdata(vram_rdata), .cx1(cx[1]), .cy1(coarse_y[1]),
        .name_byte(name_byte), .tile(tile), .load(tile_load)
    );

    always_comb begin
        vram_rd = active && !slot[0];
        case (slot)
            SL_NAME_A: vram_addr = name_addr(name_sel, coarse_y, cx);
            SL_ATTR_A: vram_addr = attr_addr(name_sel, coarse_y, cx);
            SL_LO_A:   vram_addr = pat_addr(pat_sel, name_byte, 1'b0, fine_y);
            SL_HI_A:   vram_addr = pat_addr(pat_sel, name_byte, 1'b1, fine_y);
            default:   vram_addr = '0;
        endcase
    end

    assign tile_lo  = tile.lo;
    assign tile_hi  = tile.hi;
    assign tile_pal = tile.pal;

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        vram_rd |=> !vram_rd); // R2
    AST_LOAD_STEPS_CX: assert property (@(posedge clk) disable iff (rst)
        tile_load |-> cx == CX_W'($past(cx) + 1'b1)); // R7
    AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !render_en |=> !tile_load); // R9
endmodule

// File: tb/sim_tile_fetch_seq.sv
module sim_tile_fetch_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        render_en = 1'b0;
    logic [8:0]  dot = '0;
    logic [4:0]  scroll_cx = '0;
    logic [4:0]  coarse_y = '0;
    logic [2:0]  fine_y = '0;
    logic [1:0]  name_sel = '0;
    logic        pat_sel = 1'b0;
    logic [7:0]  vram_rdata = '0;
    logic [13:0] vram_addr;
    logic        vram_rd;
    logic        tile_load;
    logic [7:0]  tile_lo, tile_hi;
    logic [1:0]  tile_pal;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tile_fetch_seq u0 (
        .clk(clk), .rst(rst), .render_en(render_en), .dot(dot),
        .scroll_cx(scroll_cx), .coarse_y(coarse_y), .fine_y(fine_y),
        .name_sel(name_sel), .pat_sel(pat_sel), .vram_rdata(vram_rdata),
        .vram_addr(vram_addr), .vram_rd(vram_rd), .tile_load(tile_load),
        .tile_lo(tile_lo), .tile_hi(tile_hi), .tile_pal(tile_pal)
    );

    function automatic logic [7:0] memf(input logic [13:0] a);
        return (a[7:0] * 8'd29) ^ a[13:6] ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bench model state
    logic [4:0]  m_cx = '0;
    logic [7:0]  m_name = '0, m_attr = '0, m_lo = '0, m_hi = '0;
    logic [1:0]  m_pal = '0;
    logic [7:0]  s_lo = '0, s_hi = '0;
    logic [1:0]  s_pal = '0;
    bit          ld_next = 0;
    bit          pend = 0;
    logic [13:0] pend_a = '0;

    task automatic cycle(input int d);
        int p;
        bit act, exp_rd;
        logic [13:0] ea;
        string rq;
        @(posedge clk);
        #1;
        if (pend) vram_rdata = memf(pend_a);
        dot = 9'(d);
        #2;
        act = render_en && ((d >= 1 && d <= 256) || (d >= 321 && d <= 336));
        p = (d - 1) & 7;
        exp_rd = act && (p % 2 == 0);
        chk(render_en ? "R2" : "R9", "strobe", int'(vram_rd), int'(exp_rd));
        ea = '0;
        if (exp_rd) begin
            case (p)
                0: begin
                    ea = {2'b10, name_sel, coarse_y, m_cx};
                    m_name = memf(ea);
                end
                2: begin
                    ea = {2'b10, name_sel, 4'b1111, coarse_y[4:2], m_cx[4:2]};
                    m_attr = memf(ea);
                    case ({coarse_y[1], m_cx[1]})
                        2'b00: m_pal = m_attr[1:0];
                        2'b01: m_pal = m_attr[3:2];
                        2'b10: m_pal = m_attr[5:4];
                        default: m_pal = m_attr[7:6];
                    endcase
                end
                4: begin
                    ea = {1'b0, pat_sel, m_name, 1'b0, fine_y};
                    m_lo = memf(ea);
                end
                default: begin
                    ea = {1'b0, pat_sel, m_name, 1'b1, fine_y};
                    m_hi = memf(ea);
                end
            endcase
            rq = "R3";
            if (p == 0 && (d == 321 || d == 1)) rq = "R8";
            else if (p == 0 && m_cx == 5'd0) rq = "R7";
            else if (p >= 4) rq = "R4";
            chk(rq, "address", int'(vram_addr), int'(ea));
        end
        chk(render_en ? "R6" : "R9", "load", int'(tile_load), int'(ld_next));
        if (ld_next) begin
            s_lo = m_lo; s_hi = m_hi; s_pal = m_pal;
        end
        chk("R4", "tile_lo", int'(tile_lo), int'(s_lo));
        chk("R4", "tile_hi", int'(tile_hi), int'(s_hi));
        chk("R5", "tile_pal", int'(tile_pal), int'(s_pal));
        pend = vram_rd;
        pend_a = vram_addr;
        ld_next = act && (p == 7);
        if (ld_next) m_cx = m_cx + 5'd1;
        if (render_en && d == 257) m_cx = scroll_cx;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk("R1", "rd in reset", int'(vram_rd), 0);
        chk("R1", "load in reset", int'(tile_load), 0);
        chk("R1", "tile in reset", int'({tile_lo, tile_hi, tile_pal}), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk("R1", "load after reset", int'(tile_load), 0);
        chk("R1", "tile after reset", int'({tile_lo, tile_hi, tile_pal}), 0);
        for (int li = 0; li < 10; li++) begin
            render_en = (li != 4);
            scroll_cx = 5'((li * 11 + 5) % 32);
            coarse_y  = 5'((li * 7 + 1) % 32);
            fine_y    = 3'(li % 8);
            name_sel  = 2'(li % 4);
            pat_sel   = li[0];
            for (int d = 0; d < 341; d++) cycle(d);
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule